// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a microcontroller's peripheral bus. Two registers control it. A direction register selects, pin by pin, whether the pad is driven. A data register holds the values that driven pins put out. Each pad is modelled as three separate signals: an incoming level, an outgoing level and an output enable. Incoming levels pass through a two-flop synchroniser before software can read them.

The direction register is write-only, and any read of it returns all ones. Its reset value depends on the operating mode presented on `mode_sel`: 0 and 1 are the two single-chip modes, and 2 and 3 are the two expanded modes. In the expanded modes the top pin carries an address line, so its direction bit is held at output.

Two standby inputs are provided. Hardware standby reinitialises the port as a reset would. Software standby freezes the port, so driven pins keep their levels. The bus is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` after the edge where `bus_rd` is high and is held until the next read. `mode_sel` is expected to change only while `rst_n` is low.

Top module: `gpio8_port`

## Requirements
- R1: A direction bit of 1 sets the matching `pin_oe` bit, and `pin_out` always shows the data register, so a driven pin outputs its data bit. A direction bit of 0 clears `pin_oe` for that pin.
- R2: A read at address 20'hEE009 (direction register) returns 8'hFF whatever the register holds.
- R3: On reset the direction register is 8'h00 when `mode_sel` is 0 or 1, and 8'h80 when `mode_sel` is 2 or 3.
- R4: When `mode_sel` is 2 or 3, direction bit 7 stays 1. A write with bit 7 clear leaves `pin_oe[7]` high while the other bits take the written value.
- R5: At a clock edge with `hw_stby` high, both registers return to their reset values, and a bus write in that same cycle is discarded.
- R6: While `sw_stby` is high (and `hw_stby` low), bus writes are ignored, and `pin_oe` and `pin_out` keep their values.
- R7: Address 20'hFFFD9 is the data register. It is read/write and resets to 8'h00.
- R8: A read of the data register returns, for each bit, the data register bit if that pin is an output, or otherwise the synchronised pad level. A pad change is seen by a read issued two or more cycles after the change, but not by a read issued in the same cycle as the change.
- R9: A write to any other address changes neither register, and a read of any other address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode: 0/1 single-chip, 2/3 expanded (top pin forced to output) |
| hw_stby | input | 1 | Hardware standby: reinitialises both registers |
| sw_stby | input | 1 | Software standby: freezes registers, ignores writes |
| bus_addr | input | 20 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held between reads |
| pin_in | input | 8 | Incoming pad levels (asynchronous) |
| pin_out | output | 8 | Outgoing pad levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
Two cases can fall in the same cycle.

The first is a bus write and a standby request. The bench raises `hw_stby` in the same cycle as a write of all ones to the direction register. It then requires the enables and outputs to show the mode's reset values, which shows that the reinitialisation took priority over the write. A separate test applies software standby together with writes to both registers. It then requires the pads to be unchanged.

The second is a pad change and a read of the data register. The bench changes `pin_in` in the same cycle that it issues a read. It expects the old level from that read, which shows the synchroniser delay, and the new level from a read two cycles later.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE_A = 2'd0,
    MODE_SINGLE_B = 2'd1,
    MODE_EXPAND_A = 2'd2,
    MODE_EXPAND_B = 2'd3
  } gpio_mode_e;

  // Expanded modes lend the top pin to the address bus.
  function automatic logic is_expanded(input gpio_mode_e m);
    return (m == MODE_EXPAND_A) || (m == MODE_EXPAND_B);
  endfunction

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gpio_mode_e       mode,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             wr,
  input  logic             hit_dir,
  input  logic             hit_dat,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_eff,
  output logic [WIDTH-1:0] dat_q
);
  localparam int MSB = WIDTH - 1;

  logic             ext_mode;
  logic [WIDTH-1:0] force_mask;
  logic [WIDTH-1:0] init_val;
  logic [WIDTH-1:0] dir_q;

  assign ext_mode   = is_expanded(mode);
  assign force_mask = ext_mode ? (WIDTH'(1) << MSB) : '0;
  assign init_val   = force_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= init_val;
      dat_q <= '0;
    end else if (hw_stby) begin
      dir_q <= init_val;
      dat_q <= '0;
    end else if (wr && !sw_stby) begin
      if (hit_dir) dir_q <= wdata | force_mask;
      if (hit_dat) dat_q <= wdata;
    end
  end

  assign dir_eff = dir_q | force_mask;

  assert_hw_reinit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == $past(init_val)) && (dat_q == '0));

  assert_sw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> $stable(dir_q) && $stable(dat_q));

  assert_forced_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> dir_q[MSB]);

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_dir && !hit_dat && !hw_stby) |=> $stable(dir_q) && $stable(dat_q));
endmodule

// File: rtl/gpio8_rdmux.sv
module gpio8_rdmux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             hit_dir,
  input  logic             hit_dat,
  input  logic [WIDTH-1:0] dir_eff,
  input  logic [WIDTH-1:0] dat_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] port_view;
  logic [WIDTH-1:0] sel_data;

  assign port_view = (dat_q & dir_eff) | (pin_sync & ~dir_eff);

  always_comb begin
    if (hit_dir)      sel_data = '1;
    else if (hit_dat) sel_data = port_view;
    else              sel_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel_data;
  end

  assert_dir_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_dir) |=> (rdata == '1));

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit_dir && !hit_dat) |=> (rdata == '0));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
  import gpio8_pkg::*;
#(
  parameter int          WIDTH    = 8,
  parameter int          ADDR_W   = 20,
  parameter int          SYNC_LEN = 2,
  parameter [ADDR_W-1:0] DIR_ADDR = 20'hEE009,
  parameter [ADDR_W-1:0] DAT_ADDR = 20'hFFFD9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  gpio_mode_e       mode;
  logic             hit_dir;
  logic             hit_dat;
  logic [WIDTH-1:0] dir_eff;
  logic [WIDTH-1:0] dat_q;
  logic [WIDTH-1:0] pin_sync;

  assign mode    = gpio_mode_e'(mode_sel);
  assign hit_dir = (bus_addr == DIR_ADDR);
  assign hit_dat = (bus_addr == DAT_ADDR);

  gpio8_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio8_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .wr(bus_wr), .hit_dir(hit_dir), .hit_dat(hit_dat),
    .wdata(bus_wdata), .dir_eff(dir_eff), .dat_q(dat_q)
  );

  gpio8_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .hit_dir(hit_dir),
    .hit_dat(hit_dat), .dir_eff(dir_eff), .dat_q(dat_q),
    .pin_sync(pin_sync), .rdata(bus_rdata)
  );

  assign pin_out = dat_q;
  assign pin_oe  = dir_eff;

  assert_top_pin_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[1] |-> pin_oe[WIDTH-1]);
endmodule

// File: tb/gpio8_port_test.sv
`timescale 1ns/1ps
module gpio8_port_test;
  localparam logic [19:0] A_DIR = 20'hEE009;
  localparam logic [19:0] A_DAT = 20'hFFFD9;
  localparam logic [19:0] A_BAD = 20'hEE00A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        hw_stby = 1'b0;
  logic        sw_stby = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio8_port uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset_single;
    logic [7:0] v;
    do_reset(2'd0);
    check("R3 mode0 oe after reset", pin_oe, 8'h00);
    check("R7 data reset on pins", pin_out, 8'h00);
    bus_read(A_DAT, v);
    check("R7 data reads zero after reset", v, 8'h00);
    do_reset(2'd1);
    check("R3 mode1 oe after reset", pin_oe, 8'h00);
  endtask

  task automatic t_basic_io;
    logic [7:0] v;
    do_reset(2'd0);
    pin_in = 8'h3C;
    bus_write(A_DIR, 8'h0F);
    bus_write(A_DAT, 8'hA5);
    check("R1 oe follows direction", pin_oe, 8'h0F);
    check("R1 out follows data", pin_out, 8'hA5);
    bus_read(A_DIR, v);
    check("R2 direction reads all ones", v, 8'hFF);
    bus_read(A_DAT, v);
    check("R8 mixed read", v, 8'h35);
    bus_write(A_DIR, 8'hF0);
    check("R1 oe after rewrite", pin_oe, 8'hF0);
    bus_read(A_DAT, v);
    check("R8 mixed read flipped", v, 8'hAC);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    bus_write(A_BAD, 8'h00);
    check("R9 oe unchanged by unmapped write", pin_oe, 8'hF0);
    check("R9 out unchanged by unmapped write", pin_out, 8'hA5);
    bus_read(A_BAD, v);
    check("R9 unmapped read zero", v, 8'h00);
  endtask

  task automatic t_sw_standby;
    @(negedge clk);
    sw_stby = 1'b1;
    bus_write(A_DIR, 8'h00);
    bus_write(A_DAT, 8'h00);
    repeat (3) @(negedge clk);
    check("R6 oe held in sw standby", pin_oe, 8'hF0);
    check("R6 out held in sw standby", pin_out, 8'hA5);
    sw_stby = 1'b0;
    bus_write(A_DAT, 8'h5A);
    check("R7 write after sw standby", pin_out, 8'h5A);
  endtask

  task automatic t_hw_standby_vs_write;
    @(negedge clk);
    hw_stby = 1'b1;
    bus_addr = A_DIR; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R5 hw standby beats write oe", pin_oe, 8'h00);
    check("R5 hw standby clears data", pin_out, 8'h00);
    hw_stby = 1'b0;
    @(negedge clk);
    check("R5 oe stays reset after release", pin_oe, 8'h00);
  endtask

  task automatic t_expanded;
    logic [7:0] v;
    do_reset(2'd2);
    check("R3 mode2 oe after reset", pin_oe, 8'h80);
    bus_write(A_DIR, 8'h00);
    check("R4 top bit survives clear", pin_oe, 8'h80);
    bus_write(A_DIR, 8'h01);
    check("R4 low bits writable", pin_oe, 8'h81);
    bus_read(A_DIR, v);
    check("R2 direction reads ones in mode2", v, 8'hFF);
    @(negedge clk);
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    check("R5 hw standby mode2 value", pin_oe, 8'h80);
    do_reset(2'd3);
    check("R3 mode3 oe after reset", pin_oe, 8'h80);
  endtask

  task automatic t_sync_latency;
    logic [7:0] v;
    do_reset(2'd0);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    @(negedge clk);
    pin_in = 8'h5A;
    bus_addr = A_DAT; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
    check("R8 same-cycle read sees old level", v, 8'h00);
    @(negedge clk);
    bus_read(A_DAT, v);
    check("R8 later read sees new level", v, 8'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset_single();
    t_basic_io();
    t_unmapped();
    t_sw_standby();
    t_hw_standby_vs_write();
    t_expanded();
    t_sync_latency();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule